// File: doc/BRIEF.md
# Dual-Rail Carry-Save Adder Row

This block is one row of 3:2 compressors for a wide multiplier tree. It takes three operand words and returns a sum word and a carry word whose total equals the total of the three inputs. Every bit of every word is carried on two wires: a positive rail that holds the value and a negative rail that holds its complement. Outputs come back in the same two-rail form, so the next row of a reduction tree can use them directly without inverters.

Each bit position first decodes its three input pairs into the eight possible three-input AND terms. These terms are shared by all four output rails. Each output rail is then the OR of the terms it selects. The datapath is therefore exactly two gate levels deep and contains no inversion stage. The row is purely combinational and has no clock.

A checker flags any bit position where an input pair is not complementary, meaning both rails are low or both are high. The outputs of a flagged position carry no meaning. Other positions are not affected by it.

Top module: `dual_rail_csa_row`

## Requirements
- R1: At every position whose inputs are well formed, `sum_pos` is 1 exactly when an odd number (1 or 3) of the three positive input rails are 1.
- R2: At every well-formed position, `sum_neg` is 1 exactly when an even number (0 or 2) of the three positive input rails are 1.
- R3: At every well-formed position, `cy_pos` is 1 exactly when two or more of the three positive input rails are 1.
- R4: At every well-formed position, `cy_neg` is 1 exactly when fewer than two of the three positive input rails are 1.
- R5: At every well-formed position, exactly two of the four output wires `sum_pos`, `sum_neg`, `cy_pos` and `cy_neg` are high.
- R6: `pair_fault[i]` is 1 exactly when at least one of the pairs (`a_pos[i]`,`a_neg[i]`), (`b_pos[i]`,`b_neg[i]`), (`c_pos[i]`,`c_neg[i]`) is 00 or 11.
- R7: `any_fault` is 1 exactly when at least one bit of `pair_fault` is 1.
- R8: Bit `i` of `cy_pos` has weight 2^(i+1) and bit `i` of `sum_pos` has weight 2^i. When all positions are well formed, A + B + C = SUM + 2·CARRY, evaluated over WIDTH+2 bits.
- R9: Each position depends only on the inputs at that same position. A fault at one position leaves the outputs and the `pair_fault` bits of all other positions unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_pos | input | WIDTH | Operand A, positive rails |
| a_neg | input | WIDTH | Operand A, complement rails |
| b_pos | input | WIDTH | Operand B, positive rails |
| b_neg | input | WIDTH | Operand B, complement rails |
| c_pos | input | WIDTH | Operand C, positive rails |
| c_neg | input | WIDTH | Operand C, complement rails |
| sum_pos | output | WIDTH | Sum word, positive rails |
| sum_neg | output | WIDTH | Sum word, complement rails |
| cy_pos | output | WIDTH | Carry word (weighted one position up), positive rails |
| cy_neg | output | WIDTH | Carry word, complement rails |
| pair_fault | output | WIDTH | Per-position flag for a non-complementary input pair |
| any_fault | output | 1 | OR of all `pair_fault` bits |

## Verification
The embedded checks assume that the three input pairs at a position are complementary. Each of them is therefore gated by that position's own well-formedness, and a position that breaks the rule is exempt from them. The main stimulus always drives every negative rail as the bitwise inverse of its positive rail, both in the directed sweep and in the random words. Faults are injected deliberately, one or two positions at a time, by forcing one rail of a pair to equal its partner. Only the fault flags and the untouched positions are compared in those cases.

// File: rtl/dr_csa_pkg.sv
package dr_csa_pkg;

    // One logical bit carried on two wires.
    typedef struct packed {
        logic pos;
        logic neg;
    } dual_t;

    // Per-position result: sum and carry, both dual rail.
    typedef struct packed {
        dual_t sum;
        dual_t cy;
    } cell_res_t;

    // Which output rail an OR plane column produces.
    typedef enum logic [1:0] {
        SEL_SUM_POS = 2'd0,
        SEL_SUM_NEG = 2'd1,
        SEL_CY_POS  = 2'd2,
        SEL_CY_NEG  = 2'd3
    } plane_sel_e;

    localparam int unsigned OPERANDS = 3;
    localparam int unsigned TERMS    = 1 << OPERANDS;
    localparam int unsigned PLANES   = 4;

    // Count of true operands selected by a minterm index.
    function automatic int unsigned ones_in(input logic [OPERANDS-1:0] idx);
        int unsigned n;
        n = 0;
        for (int k = 0; k < OPERANDS; k++) begin
            n += int'(idx[k]);
        end
        return n;
    endfunction

    // Which of the shared minterms each output rail gathers.
    function automatic logic [TERMS-1:0] plane_mask(input plane_sel_e sel);
        logic [TERMS-1:0] m;
        m = '0;
        for (int t = 0; t < TERMS; t++) begin
            case (sel)
                SEL_SUM_POS: m[t] = (ones_in(OPERANDS'(t)) % 2) == 1;
                SEL_SUM_NEG: m[t] = (ones_in(OPERANDS'(t)) % 2) == 0;
                SEL_CY_POS:  m[t] = ones_in(OPERANDS'(t)) >= 2;
                default:     m[t] = ones_in(OPERANDS'(t)) < 2;
            endcase
        end
        return m;
    endfunction

    // A pair is well formed when exactly one of its rails is high.
    function automatic logic pair_ok(input dual_t d);
        return d.pos ^ d.neg;
    endfunction

endpackage

// File: rtl/dr_csa_terms.sv
module dr_csa_terms
    import dr_csa_pkg::*;
(
    input  dual_t              x_i,
    input  dual_t              y_i,
    input  dual_t              z_i,
    output logic [TERMS-1:0]   term_o
);

    // First logic level: one AND3 per minterm, bit 2 of the index is x.
    for (genvar m = 0; m < TERMS; m++) begin : g_term
        localparam logic [OPERANDS-1:0] K = OPERANDS'(m);
        assign term_o[m] = (K[2] ? x_i.pos : x_i.neg)
                         & (K[1] ? y_i.pos : y_i.neg)
                         & (K[0] ? z_i.pos : z_i.neg);
    end

    // With well-formed pairs exactly one shared minterm is active.
    always_comb begin
        if (pair_ok(x_i) && pair_ok(y_i) && pair_ok(z_i)) begin
            assert_one_term_R5: assert ($countones(term_o) == 1)
                else $error("more or fewer than one minterm active");
        end
    end

endmodule

// File: rtl/dr_csa_plane.sv
module dr_csa_plane
    import dr_csa_pkg::*;
(
    input  logic [TERMS-1:0] term_i,
    output cell_res_t        res_o
);

    logic [PLANES-1:0] rail;

    // Second logic level: each rail is an OR over its selected minterms.
    for (genvar s = 0; s < PLANES; s++) begin : g_plane
        localparam logic [TERMS-1:0] MASK = plane_mask(plane_sel_e'(s));
        assign rail[s] = |(term_i & MASK);
    end

    assign res_o.sum.pos = rail[SEL_SUM_POS];
    assign res_o.sum.neg = rail[SEL_SUM_NEG];
    assign res_o.cy.pos  = rail[SEL_CY_POS];
    assign res_o.cy.neg  = rail[SEL_CY_NEG];

endmodule

// File: rtl/dr_csa_guard.sv
module dr_csa_guard
    import dr_csa_pkg::*;
(
    input  dual_t x_i,
    input  dual_t y_i,
    input  dual_t z_i,
    output logic  fault_o
);

    // Checker only, off the datapath.
    assign fault_o = !(pair_ok(x_i) && pair_ok(y_i) && pair_ok(z_i));

endmodule

// File: rtl/dr_csa_cell.sv
module dr_csa_cell
    import dr_csa_pkg::*;
(
    input  dual_t     x_i,
    input  dual_t     y_i,
    input  dual_t     z_i,
    output cell_res_t res_o,
    output logic      fault_o
);

    logic [TERMS-1:0] term;

    dr_csa_terms u_terms (
        .x_i    (x_i),
        .y_i    (y_i),
        .z_i    (z_i),
        .term_o (term)
    );

    dr_csa_plane u_plane (
        .term_i (term),
        .res_o  (res_o)
    );

    dr_csa_guard u_guard (
        .x_i     (x_i),
        .y_i     (y_i),
        .z_i     (z_i),
        .fault_o (fault_o)
    );

    always_comb begin
        if (!fault_o) begin
            assert_sum_parity_R1: assert (res_o.sum.pos == (x_i.pos ^ y_i.pos ^ z_i.pos))
                else $error("sum rail disagrees with input parity");
            assert_sum_pair_R2: assert (res_o.sum.pos != res_o.sum.neg)
                else $error("sum rails not complementary");
            assert_cy_major_R3: assert (res_o.cy.pos ==
                    ((x_i.pos & y_i.pos) | (x_i.pos & z_i.pos) | (y_i.pos & z_i.pos)))
                else $error("carry rail disagrees with majority");
            assert_cy_pair_R4: assert (res_o.cy.pos != res_o.cy.neg)
                else $error("carry rails not complementary");
            assert_two_high_R5: assert ($countones({res_o.sum, res_o.cy}) == 2)
                else $error("output wires high count is not two");
        end
    end

endmodule

// File: rtl/dual_rail_csa_row.sv
module dual_rail_csa_row
    import dr_csa_pkg::*;
#(
    parameter int unsigned WIDTH = 64
) (
    input  logic [WIDTH-1:0] a_pos,
    input  logic [WIDTH-1:0] a_neg,
    input  logic [WIDTH-1:0] b_pos,
    input  logic [WIDTH-1:0] b_neg,
    input  logic [WIDTH-1:0] c_pos,
    input  logic [WIDTH-1:0] c_neg,
    output logic [WIDTH-1:0] sum_pos,
    output logic [WIDTH-1:0] sum_neg,
    output logic [WIDTH-1:0] cy_pos,
    output logic [WIDTH-1:0] cy_neg,
    output logic [WIDTH-1:0] pair_fault,
    output logic             any_fault
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_pos
        dual_t     xa, xb, xc;
        cell_res_t res;

        assign xa = '{pos: a_pos[i], neg: a_neg[i]};
        assign xb = '{pos: b_pos[i], neg: b_neg[i]};
        assign xc = '{pos: c_pos[i], neg: c_neg[i]};

        dr_csa_cell u_cell (
            .x_i     (xa),
            .y_i     (xb),
            .z_i     (xc),
            .res_o   (res),
            .fault_o (pair_fault[i])
        );

        assign sum_pos[i] = res.sum.pos;
        assign sum_neg[i] = res.sum.neg;
        assign cy_pos[i]  = res.cy.pos;
        assign cy_neg[i]  = res.cy.neg;
    end

    assign any_fault = |pair_fault;

    always_comb begin
        assert_any_fault_R7: assert (any_fault == (pair_fault != '0))
            else $error("summary fault flag disagrees with per-position flags");
    end

endmodule

// File: tb/sim_dual_rail_csa_row.sv
module sim_dual_rail_csa_row;

    localparam int W = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;   // 20 ns period, 50 MHz

    logic [W-1:0] a_pos, a_neg, b_pos, b_neg, c_pos, c_neg;
    logic [W-1:0] sum_pos, sum_neg, cy_pos, cy_neg, pair_fault;
    logic         any_fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [W-1:0] av, bv, cv;

    dual_rail_csa_row #(.WIDTH(W)) u0 (
        .a_pos(a_pos), .a_neg(a_neg), .b_pos(b_pos), .b_neg(b_neg),
        .c_pos(c_pos), .c_neg(c_neg),
        .sum_pos(sum_pos), .sum_neg(sum_neg), .cy_pos(cy_pos), .cy_neg(cy_neg),
        .pair_fault(pair_fault), .any_fault(any_fault)
    );

    function automatic logic [W-1:0] ref_sum(input logic [W-1:0] a, b, c);
        return a ^ b ^ c;
    endfunction

    function automatic logic [W-1:0] ref_cy(input logic [W-1:0] a, b, c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    task automatic chk(input string req, input logic [W+1:0] act, input logic [W+1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [W-1:0] a, b, c);
        @(negedge clk);
        av = a; bv = b; cv = c;
        a_pos = a; a_neg = ~a;
        b_pos = b; b_neg = ~b;
        c_pos = c; c_neg = ~c;
        #2;
    endtask

    // Full comparison for a word set whose pairs are all well formed.
    task automatic check_all();
        logic [W+1:0] lhs, rhs;
        logic [W-1:0] two_ok;
        chk("R1", {2'b0, sum_pos}, {2'b0, ref_sum(av, bv, cv)});
        chk("R2", {2'b0, sum_neg}, {2'b0, ~ref_sum(av, bv, cv)});
        chk("R3", {2'b0, cy_pos},  {2'b0, ref_cy(av, bv, cv)});
        chk("R4", {2'b0, cy_neg},  {2'b0, ~ref_cy(av, bv, cv)});
        for (int i = 0; i < W; i++) begin
            two_ok[i] = (32'(sum_pos[i]) + 32'(sum_neg[i]) + 32'(cy_pos[i]) + 32'(cy_neg[i])) == 2;
        end
        chk("R5", {2'b0, two_ok}, {2'b0, {W{1'b1}}});
        chk("R6", {2'b0, pair_fault}, '0);
        chk("R7", {{(W+1){1'b0}}, any_fault}, '0);
        lhs = {2'b0, av} + {2'b0, bv} + {2'b0, cv};
        rhs = {2'b0, sum_pos} + {1'b0, cy_pos, 1'b0};
        chk("R8", rhs, lhs);
    endtask

    initial begin
        void'($urandom(32'd4711));
        av = '0; bv = '0; cv = '0;
        a_pos = '0; a_neg = '1; b_pos = '0; b_neg = '1; c_pos = '0; c_neg = '1;
        repeat (3) @(posedge clk);
        // Idle state during reset: all operands zero.
        @(negedge clk);
        chk("R2 idle", {2'b0, sum_neg}, {2'b0, {W{1'b1}}});
        chk("R4 idle", {2'b0, cy_neg},  {2'b0, {W{1'b1}}});
        chk("R1 idle", {2'b0, sum_pos | cy_pos}, '0);
        rst = 1'b0;

        // All eight combinations at every position, rotated across the word.
        for (int k = 0; k < 8; k++) begin
            logic [W-1:0] a, b, c;
            for (int i = 0; i < W; i++) begin
                logic [2:0] cmb;
                cmb = 3'((i + k) % 8);
                a[i] = cmb[2]; b[i] = cmb[1]; c[i] = cmb[0];
            end
            drive(a, b, c);
            check_all();
        end

        // Directed extremes.
        drive('1, '1, '1);  check_all();
        drive('1, '0, '0);  check_all();
        drive('1, '1, '0);  check_all();
        drive({W/2{2'b10}}, {W/2{2'b01}}, '1); check_all();

        // Random words.
        for (int n = 0; n < 200; n++) begin
            drive({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom});
            check_all();
        end

        // Fault injection: both-low and both-high pairs at chosen positions.
        for (int n = 0; n < 24; n++) begin
            int unsigned k, op;
            logic [W-1:0] hit, keep;
            drive({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom});
            k  = $urandom % W;
            op = $urandom % 3;
            hit = '0; hit[k] = 1'b1;
            @(negedge clk);
            case (op)
                0: if (n % 2 == 0) a_pos[k] = a_neg[k]; else a_neg[k] = a_pos[k];
                1: if (n % 2 == 0) b_pos[k] = b_neg[k]; else b_neg[k] = b_pos[k];
                default: if (n % 2 == 0) c_pos[k] = c_neg[k]; else c_neg[k] = c_pos[k];
            endcase
            #2;
            chk("R6 single fault", {2'b0, pair_fault}, {2'b0, hit});
            chk("R7 single fault", {{(W+1){1'b0}}, any_fault}, {{(W+1){1'b0}}, 1'b1});
            keep = ~hit;
            chk("R9 sum isolation", {2'b0, sum_pos & keep}, {2'b0, ref_sum(av, bv, cv) & keep});
            chk("R9 carry isolation", {2'b0, cy_neg & keep}, {2'b0, ~ref_cy(av, bv, cv) & keep});
        end

        // Two faulted positions at the ends of the word.
        drive('0, '1, '0);
        @(negedge clk);
        a_pos[0] = 1'b1;            // a pair 11 at bit 0
        c_neg[W-1] = 1'b0;          // c pair 00 at top bit
        #2;
        chk("R6 ends", {2'b0, pair_fault}, {2'b0, 1'b1, {(W-2){1'b0}}, 1'b1});
        chk("R7 ends", {{(W+1){1'b0}}, any_fault}, {{(W+1){1'b0}}, 1'b1});
        chk("R9 ends", {2'b0, sum_pos[W-2:1], 2'b0}, {2'b0, {(W-2){1'b1}}, 2'b0});

        // Recovery after faults removed.
        drive({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom});
        check_all();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule